// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block collects eight interrupt request lines, holds them in a request register and filters them through a software mask. It resolves the remaining requests against a priority order that can be rotated, and tracks the levels being serviced in an in-service register. When a request is eligible, it raises a single interrupt output. When the processor pulses the acknowledge input, the block answers one cycle later with an 8-bit vector equal to a programmed base plus the winning level.

Software talks to the block through two register addresses: a command address (`addr` = 0) and a data address (`addr` = 1). The block is configured by an initialisation sequence of two to four words, and some of those words are present only when earlier words ask for them. After that sequence, the same two addresses carry the operation words: mask loads, end-of-interrupt variants, priority rotation, register read-back selection, polling and special mask mode.

The cascade configuration word and the mode word are stored and brought out unchanged. The block uses only the mode word's automatic end-of-interrupt bit.

Top module: `irqc_top`

## Requirements
- R1: A command-address write with bit 4 set starts initialisation. In that word, bit 0 set means a mode word will follow, bit 1 set selects single mode, and bit 3 set selects level-sensitive inputs. The next data-address write is the vector base. The write after it is taken as the cascade word (shown on `casc_word`) only when bit 1 was clear, and the mode word (shown on `mode_word`) follows only when bit 0 was set. After the sequence, data-address writes load the mask, and a command-address read returns that mask.
- R2: Starting initialisation clears the mask, the request register, the in-service register, special mask mode and any armed poll. It also returns the data-address read selection to the request register and restores the default priority order.
- R3: One cycle after an `inta` pulse, `vec_valid` is high and `vec_out` holds (base + acknowledged level) modulo 256.
- R4: With the default order, level 0 has the highest priority and level 7 the lowest.
- R5: When mask bit n is 1, line n cannot raise `int_out` and cannot be acknowledged. A mask of 0x00 lets every line through.
- R6: In edge mode, a request bit is set by a rising edge on its line and stays set until that level is acknowledged. In level mode, the request register follows the inputs.
- R7: Outside special mask mode, a request raises `int_out` only if it is unmasked and has strictly higher priority than every level in service. Each acknowledge sets at most one in-service bit.
- R8: A command-address write with bits [4:3] = 00 is an operation word, and its bits [7:5] select the action. Code 001 clears the highest-priority in-service bit. Code 011 clears the in-service bit named in bits [2:0].
- R9: In that operation word, code 101 clears the highest-priority in-service bit and makes that level the lowest priority. Code 111 does the same for the level in bits [2:0]. Code 110 only makes the level in bits [2:0] the lowest priority.
- R10: When bit 1 of the mode word is set, an acknowledge leaves the in-service register unchanged. Operation code 100 then makes each acknowledged level the lowest priority, and code 000 stops this.
- R11: A command write of 0x68 enters special mask mode and 0x48 leaves it. While the mode is on, any unmasked request that is not itself in service may interrupt.
- R12: A command-address write with bits [4:3] = 01 is a read-control word. The value 0x0A makes data-address reads return the request register, and 0x0B makes them return the in-service register.
- R13: After a command write of 0x0C, the next data-address read returns bit 7 set and the highest eligible level in bits [2:0], and it acknowledges that level as `inta` would. If no level is eligible, the read returns 0x00.
- R14: An `inta` pulse with no eligible request returns base + 7 and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 selects the command address, 1 the data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Registered interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge pulse |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | High for one cycle when `vec_out` is new |
| casc_word | output | 8 | Stored cascade configuration word |
| mode_word | output | 8 | Stored mode word |

## Verification
The bench builds the block with its default of eight lines and a 3-bit level field. With that build it can reach every level, the wrap of the rotating lowest-priority pointer from 7 back to 0, and both specific-level encodings at the ends of the field. Random vector bases cover the whole byte, so a base near 0xFF checks that base plus level wraps modulo 256. Random masks and request patterns are run against a bench priority function.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    IS_READY = 2'd0,
    IS_BASE  = 2'd1,
    IS_CASC  = 2'd2,
    IS_MODE  = 2'd3
  } init_state_t;

  // operation word action codes, bits [7:5]
  localparam logic [2:0] OP_ROT_AEOI_CLR = 3'b000;
  localparam logic [2:0] OP_EOI_NS       = 3'b001;
  localparam logic [2:0] OP_NOP          = 3'b010;
  localparam logic [2:0] OP_EOI_SP       = 3'b011;
  localparam logic [2:0] OP_ROT_AEOI_SET = 3'b100;
  localparam logic [2:0] OP_ROT_NS       = 3'b101;
  localparam logic [2:0] OP_SET_LOW      = 3'b110;
  localparam logic [2:0] OP_ROT_SP       = 3'b111;
endpackage

// File: rtl/irqc_init.sv
module irqc_init
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          init_start,
  output logic          mask_wr,
  output logic          opw_wr,
  output logic          rdc_wr,
  output logic [DW-1:0] base,
  output logic          level_mode,
  output logic          aeoi,
  output logic [DW-1:0] casc_word,
  output logic [DW-1:0] mode_word
);
  init_state_t state_q;
  logic        single_q, want_mode_q;
  logic        cmd_wr, dat_wr, ready;

  assign cmd_wr     = wr_en && !addr;
  assign dat_wr     = wr_en && addr;
  assign ready      = (state_q == IS_READY);
  assign init_start = cmd_wr && wdata[4];
  assign mask_wr    = dat_wr && ready;
  assign opw_wr     = cmd_wr && ready && (wdata[4:3] == 2'b00);
  assign rdc_wr     = cmd_wr && ready && (wdata[4:3] == 2'b01);
  assign aeoi       = mode_word[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= IS_READY;
      base        <= '0;
      single_q    <= 1'b1;
      want_mode_q <= 1'b0;
      level_mode  <= 1'b0;
      casc_word   <= '0;
      mode_word   <= '0;
    end else if (init_start) begin
      state_q     <= IS_BASE;
      want_mode_q <= wdata[0];
      single_q    <= wdata[1];
      level_mode  <= wdata[3];
      mode_word   <= '0;
    end else if (dat_wr) begin
      unique case (state_q)
        IS_BASE: begin
          base <= wdata;
          if (!single_q)        state_q <= IS_CASC;
          else if (want_mode_q) state_q <= IS_MODE;
          else                  state_q <= IS_READY;
        end
        IS_CASC: begin
          casc_word <= wdata;
          state_q   <= want_mode_q ? IS_MODE : IS_READY;
        end
        IS_MODE: begin
          mode_word <= wdata;
          state_q   <= IS_READY;
        end
        default: state_q <= IS_READY;
      endcase
    end
  end
endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic         level_mode,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        irr[g]    <= 1'b0;
        prev_q[g] <= 1'b0;
      end else if (clr_all) begin
        irr[g]    <= 1'b0;
        prev_q[g] <= lines[g];
      end else begin
        prev_q[g] <= lines[g];
        if (level_mode) irr[g] <= lines[g];
        else            irr[g] <= (irr[g] & ~ack_clr[g]) | (lines[g] & ~prev_q[g]);
      end
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] lowest,
  output logic          hit,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  // scan from the lowest-priority end so the last match is the winner
  always_comb begin
    hit  = 1'b0;
    lvl  = '0;
    rank = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[lowest + LW'(i + 1)]) begin
        hit  = 1'b1;
        lvl  = lowest + LW'(i + 1);
        rank = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             int_out,
  input  logic             inta,
  output logic [DW-1:0]    vec_out,
  output logic             vec_valid,
  output logic [DW-1:0]    casc_word,
  output logic [DW-1:0]    mode_word
);
  localparam int LW = $clog2(N_IRQ);
  localparam logic [LW-1:0] LVL_LAST = LW'(N_IRQ - 1);

  logic             init_start, mask_wr, opw_wr, rdc_wr, level_mode, aeoi;
  logic [DW-1:0]    base;
  logic [N_IRQ-1:0] irr, imr_q, isr_q, pend, ack_clr, isr_clr, isr_set;
  logic [LW-1:0]    lowest_q, req_lvl, req_rank, isr_lvl, isr_rank, op_lvl;
  logic             req_hit, isr_hit, eligible;
  logic             rot_aeoi_q, smm_q, sel_isr_q, poll_q;
  logic             poll_rd, ack, ack_hit;
  logic [2:0]       op;

  function automatic logic [N_IRQ-1:0] bit_of(input logic [LW-1:0] l);
    return N_IRQ'(1) << l;
  endfunction

  irqc_init u_init (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .init_start(init_start), .mask_wr(mask_wr), .opw_wr(opw_wr), .rdc_wr(rdc_wr),
    .base(base), .level_mode(level_mode), .aeoi(aeoi),
    .casc_word(casc_word), .mode_word(mode_word)
  );

  irqc_req_latch #(.N(N_IRQ)) u_req (
    .clk(clk), .rst(rst), .clr_all(init_start), .level_mode(level_mode),
    .lines(irq_in), .ack_clr(ack_clr), .irr(irr)
  );

  assign pend = smm_q ? (irr & ~imr_q & ~isr_q) : (irr & ~imr_q);

  irqc_prio #(.N(N_IRQ), .LW(LW)) u_prio_req (
    .vec(pend), .lowest(lowest_q), .hit(req_hit), .lvl(req_lvl), .rank(req_rank)
  );

  irqc_prio #(.N(N_IRQ), .LW(LW)) u_prio_isr (
    .vec(isr_q), .lowest(lowest_q), .hit(isr_hit), .lvl(isr_lvl), .rank(isr_rank)
  );

  assign eligible = req_hit && (smm_q || !isr_hit || (req_rank < isr_rank));
  assign poll_rd  = rd_en && addr && poll_q;
  assign ack      = inta || poll_rd;
  assign ack_hit  = ack && eligible;
  assign ack_clr  = (ack_hit && !level_mode) ? bit_of(req_lvl) : '0;
  assign isr_set  = (ack_hit && !aeoi) ? bit_of(req_lvl) : '0;
  assign op       = wdata[7:5];
  assign op_lvl   = wdata[LW-1:0];

  always_comb begin
    isr_clr = '0;
    if (opw_wr) begin
      unique case (op)
        OP_EOI_NS, OP_ROT_NS: isr_clr = isr_hit ? bit_of(isr_lvl) : '0;
        OP_EOI_SP, OP_ROT_SP: isr_clr = bit_of(op_lvl);
        default:              isr_clr = '0;
      endcase
    end
  end

  // mask, in-service and priority state
  always_ff @(posedge clk) begin
    if (rst || init_start) begin
      imr_q      <= '0;
      isr_q      <= '0;
      lowest_q   <= LVL_LAST;
      rot_aeoi_q <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (mask_wr) imr_q <= wdata[N_IRQ-1:0];
      if (opw_wr) begin
        unique case (op)
          OP_ROT_NS:       if (isr_hit) lowest_q <= isr_lvl;
          OP_ROT_SP,
          OP_SET_LOW:      lowest_q <= op_lvl;
          OP_ROT_AEOI_SET: rot_aeoi_q <= 1'b1;
          OP_ROT_AEOI_CLR: rot_aeoi_q <= 1'b0;
          default:         ;
        endcase
      end
      if (ack_hit && aeoi && rot_aeoi_q) lowest_q <= req_lvl;
    end
  end

  // read-control state
  always_ff @(posedge clk) begin
    if (rst || init_start) begin
      smm_q     <= 1'b0;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
    end else if (rdc_wr) begin
      if (wdata[1]) sel_isr_q <= wdata[0];
      if (wdata[6]) smm_q     <= wdata[5];
      poll_q <= wdata[2];
    end else if (rd_en && addr) begin
      poll_q <= 1'b0;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      int_out   <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      int_out   <= eligible && !ack && !init_start;
      vec_valid <= inta;
      if (inta) vec_out <= base + DW'(eligible ? req_lvl : LVL_LAST);
      if (rd_en) begin
        if (!addr)       rdata <= DW'(imr_q);
        else if (poll_q) rdata <= {eligible, 4'b0000, eligible ? 3'(req_lvl) : 3'b000};
        else             rdata <= sel_isr_q ? DW'(isr_q) : DW'(irr);
      end
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         inta,
  input logic         vec_valid,
  input logic         int_out,
  input logic         aeoi,
  input logic         smm,
  input logic         init_start,
  input logic [N-1:0] irr,
  input logic [N-1:0] imr,
  input logic [N-1:0] isr
);
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(inta)); // R3

  AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past((irr & ~imr) != '0)); // R5

  AST_ONE_ISR_PER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(int_out) |-> ($countones(isr & ~$past(isr)) <= 1)); // R7

  AST_ISR_SINGLE_SET: assert property (@(posedge clk) disable iff (rst)
    inta |=> ($countones(isr & ~$past(isr)) <= 1)); // R7

  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
    (inta && aeoi) |=> ((isr & ~$past(isr)) == '0)); // R10

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    init_start |=> (imr == '0 && isr == '0 && !smm)); // R2
endmodule

bind irqc_top irqc_checker #(.N(N_IRQ)) u_chk (
  .clk(clk), .rst(rst), .inta(inta), .vec_valid(vec_valid), .int_out(int_out),
  .aeoi(aeoi), .smm(smm_q), .init_start(init_start),
  .irr(irr), .imr(imr_q), .isr(isr_q)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
  logic       clk = 1'b0, rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, vec_out, casc_word, mode_word;
  logic       int_out, vec_valid;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] d;

  always #2.5 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .inta(inta),
    .vec_out(vec_out), .vec_valid(vec_valid), .casc_word(casc_word), .mode_word(mode_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0; v = vec_out;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk); irq_in = '0;
    settle();
  endtask

  // highest pending level for a given lowest-priority level, -1 if none
  function automatic int pick(input logic [7:0] p, input int low);
    for (int i = 1; i <= 8; i++) if (p[(low + i) % 8]) return (low + i) % 8;
    return -1;
  endfunction

  initial begin
    repeat (50000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset int_out", int_out, 0);
    chk("reset vec_valid", vec_valid, 0);
    rd(1, d); chk("reset request read", d, 8'h00);

    // R1 init sequences
    wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h01);
    chk("R1 mode word", mode_word, 8'h01);
    wr(1, 8'hA5); rd(0, d); chk("R1 mask after 3-word init", d, 8'hA5);
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h01);
    chk("R1 cascade word", casc_word, 8'h04);
    rd(0, d); chk("R2 mask cleared by init", d, 8'h00);
    wr(1, 8'h3C); rd(0, d); chk("R1 mask after 4-word init", d, 8'h3C);
    wr(1, 8'h00); pulse(8'h80); ack(d);
    chk("R3 vector base 0x40 level 7", d, 8'h47);

    // R6 R3 R4 R7 R8 R12 R5
    wr(0, 8'h12); wr(1, 8'h20);
    @(negedge clk); irq_in = 8'h28; settle();
    chk("R6 int raised on edge", int_out, 1);
    wr(0, 8'h0A); rd(1, d); chk("R12 request register read", d, 8'h28);
    @(negedge clk); irq_in = 8'h00; settle();
    rd(1, d); chk("R6 edge request held", d, 8'h28);
    ack(d); chk("R3 vec_valid", vec_valid, 1);
    chk("R4 level 3 beats 5", d, 8'h23);
    wr(0, 8'h0B); rd(1, d); chk("R12 in-service read", d, 8'h08);
    settle(); chk("R7 lower level blocked", int_out, 0);
    wr(0, 8'h20); settle();
    chk("R8 non-specific EOI unblocks", int_out, 1);
    rd(1, d); chk("R8 in-service cleared", d, 8'h00);
    ack(d); chk("R3 vector level 5", d, 8'h25);
    wr(0, 8'h65); rd(1, d); chk("R8 specific EOI", d, 8'h00);
    wr(1, 8'h02); pulse(8'h02); chk("R5 masked line quiet", int_out, 0);
    wr(1, 8'h00); settle(); chk("R5 unmasked line raises", int_out, 1);
    ack(d); chk("R5 vector after unmask", d, 8'h21);
    wr(0, 8'h20);

    // R9 rotation
    pulse(8'h11); ack(d); chk("R9 first level 0", d, 8'h20);
    wr(0, 8'hA0); pulse(8'h01); ack(d);
    chk("R9 rotate non-specific makes 0 lowest", d, 8'h24);
    wr(0, 8'h20); ack(d); chk("R9 level 0 after 4", d, 8'h20); wr(0, 8'h20);
    wr(0, 8'hC5); pulse(8'h44); ack(d);
    chk("R9 set lowest 5 favours 6", d, 8'h26);
    wr(0, 8'h20); ack(d); chk("R9 then level 2", d, 8'h22); wr(0, 8'h20);
    wr(0, 8'hE3); pulse(8'h18); ack(d);
    chk("R9 rotate specific makes 3 lowest", d, 8'h24);
    wr(0, 8'h20); ack(d); chk("R9 then level 3", d, 8'h23); wr(0, 8'h20);
    ack(d); chk("R14 spurious vector", d, 8'h27);
    rd(1, d); chk("R14 in-service untouched", d, 8'h00);

    // R6 level mode
    wr(0, 8'h1A); wr(1, 8'h60);
    @(negedge clk); irq_in = 8'h04; settle();
    chk("R6 level int", int_out, 1);
    rd(1, d); chk("R6 level request read", d, 8'h04);
    @(negedge clk); irq_in = 8'h00; settle();
    rd(1, d); chk("R6 level request follows input", d, 8'h00);
    chk("R6 level int drops", int_out, 0);

    // R10 automatic EOI
    wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h03);
    pulse(8'h02); ack(d); chk("R10 vector", d, 8'h21);
    wr(0, 8'h0B); rd(1, d); chk("R10 in-service stays empty", d, 8'h00);
    wr(0, 8'h80); pulse(8'h03); ack(d); chk("R10 level 0 first", d, 8'h20);
    pulse(8'h01); ack(d); chk("R10 rotation at acknowledge", d, 8'h21);

    // R11 special mask mode, R2 clearing
    wr(0, 8'h12); wr(1, 8'h20);
    pulse(8'h20); ack(d); chk("R11 level 5", d, 8'h25);
    pulse(8'h40); chk("R7 level 6 blocked", int_out, 0);
    wr(0, 8'h68); settle(); chk("R11 special mask lets 6 in", int_out, 1);
    ack(d); chk("R11 vector 6", d, 8'h26);
    wr(0, 8'h0B); rd(1, d); chk("R11 two in service", d, 8'h60);
    wr(0, 8'h12); wr(1, 8'h20);
    pulse(8'h08); rd(1, d); chk("R2 read selection reset", d, 8'h08);
    ack(d); pulse(8'h10); chk("R2 special mask cleared", int_out, 0);
    wr(0, 8'h0B); rd(1, d); chk("R2 in-service reset", d, 8'h08);
    wr(0, 8'h68); ack(d); chk("R11 level 4 under special mask", d, 8'h24);
    wr(0, 8'h20); rd(1, d); chk("R8 clears highest of two", d, 8'h10);
    wr(0, 8'h48); settle(); chk("R11 leave special mask", int_out, 0);

    // R13 poll
    wr(0, 8'h12); wr(1, 8'h20);
    pulse(8'h44); wr(0, 8'h0C); rd(1, d); chk("R13 poll result", d, 8'h82);
    wr(0, 8'h0B); rd(1, d); chk("R13 poll acknowledges", d, 8'h04);
    wr(1, 8'h40); wr(0, 8'h0C); rd(1, d); chk("R13 poll nothing eligible", d, 8'h00);

    // random masks and patterns: R3 R4 R5 R14
    begin
      logic [7:0] b, m, p, pend;
      int lv;
      b = 8'($urandom(32'd20240611));
      for (int it = 0; it < 40; it++) begin
        b = 8'($urandom); m = 8'($urandom); p = 8'($urandom);
        if (it % 5 == 0) m = 8'h00;
        if (it % 7 == 0) m = 8'hFF;
        wr(0, 8'h12); wr(1, b); wr(1, m);
        pulse(p);
        pend = p & ~m;
        lv = pick(pend, 7);
        chk("R5 random int_out", int_out, (pend != 0));
        ack(d);
        chk("R4 random vector", d, (lv < 0) ? 8'(b + 8'd7) : 8'(b + 8'(lv)));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule